// File: doc/BRIEF.md
# Configurable AND-OR-INVERT Logic Unit

This block is a programmable Boolean function generator meant to sit beside a signal crossbar. Each output unit takes four single-bit inputs, called A, B, C and D, and drives one result bit. The unit forms four product terms. Inside every term, each of the four inputs is first conditioned by a 2-bit code: it can be passed through, inverted, forced high or forced low. The four terms are then ORed together to give the unit's result. With these codes a single unit can build functions such as a two-of-three majority ORed with a fourth signal, an exclusive OR, or a wide AND.

The path from the signal inputs to the result is purely combinational, so a result follows its inputs in the same cycle and can be routed straight back into the crossbar. The condition codes sit in two 16-bit words per unit, held in flip-flops and loaded through a plain synchronous write port with a combinational read-back. The parameter `UNITS` sets how many independent output units share this one register space.

Top module: `aoi_logic_top`

## Requirements
- R1: While `rst_n` is low, and right after it goes high, every stored word reads back as 0 and every bit of `fn_out` is 0.
- R2: Code 2'b01 passes the input unchanged into its product term.
- R3: Code 2'b11 forces the input to one, so the term does not depend on it. If every field of a unit's first word is 2'b11, that unit's output is 1.
- R4: Code 2'b00 forces the input to zero, which turns off the whole term. If both words of a unit are zero, that unit's output is 0.
- R5: Code 2'b10 feeds the complement of the input into its term.
- R6: A unit's output is the OR of its four product terms. Each term is the AND of its four conditioned inputs.
- R7: Word 0 of a unit holds term 0 in bits 15:8 and term 1 in bits 7:0. Word 1 holds term 2 in bits 15:8 and term 3 in bits 7:0. Inside each byte, input A uses bits 7:6, B uses 5:4, C uses 3:2 and D uses 1:0. On `sig_in`, unit u takes A from bit 4u+3, B from 4u+2, C from 4u+1 and D from 4u.
- R8: `cfg_addr` equals 2*unit + word. When `cfg_we` is high at a rising clock edge, `cfg_wdata` goes into that word. `cfg_rdata` then returns the stored value in the same cycle.
- R9: A write changes only the word it addresses. The other words, and the outputs of the other units, do not change.
- R10: A write to an address at or above 2*UNITS is dropped. Reading such an address returns 0.
- R11: `fn_out` follows `sig_in` combinationally, with no clock edge in between.
- R12: The word pair 0x5F77/0xD7FD gives (A&B)|(A&C)|(B&C)|D. The pair 0x7FDF/0xF700 gives A|B|C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration words |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration words |
| cfg_addr | input | $clog2(UNITS)+1 | Word address, equal to 2*unit + word |
| cfg_wdata | input | 16 | Value to write |
| cfg_rdata | output | 16 | Value of the addressed word, or 0 if unmapped |
| sig_in | input | 4*UNITS | Signal inputs, four per unit, A in the top bit |
| fn_out | output | UNITS | One result bit per unit |

## Verification
The only state in this block is its stored condition codes. A wrong code, whether from a write landing in the wrong word or byte or from a bad reset, shows up at the ports in two ways. It shows on `cfg_rdata` in the first cycle after the write. It also shows on `fn_out` as soon as an input pattern reaches the affected term. For that reason, every loaded configuration is swept through all sixteen input patterns and compared against an independently computed result. Cross-unit leakage and dropped unmapped writes are caught by reading back every word and probing the outputs of the units that were not written.

// File: rtl/aoi_pkg.sv
package aoi_pkg;

    localparam int LANES  = 4;
    localparam int TERMS  = 4;
    localparam int WORD_W = 16;
    localparam int CODE_W = 2;
    localparam int TCFG_W = LANES * CODE_W;

    typedef enum logic [CODE_W-1:0] {
        CODE_ZERO = 2'b00,
        CODE_PASS = 2'b01,
        CODE_INV  = 2'b10,
        CODE_ONE  = 2'b11
    } cond_code_e;

    typedef logic [TCFG_W-1:0] term_cfg_t;

    function automatic logic condition_lane(input cond_code_e code, input logic x);
        logic r;
        unique case (code)
            CODE_ZERO: r = 1'b0;
            CODE_PASS: r = x;
            CODE_INV:  r = ~x;
            CODE_ONE:  r = 1'b1;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aoi_term.sv
module aoi_term
    import aoi_pkg::*;
(
    input  term_cfg_t         cfg,
    input  logic [LANES-1:0]  lanes,
    output logic              term_o
);

    logic [LANES-1:0] conditioned;

    // lane l uses field bits [2l+1:2l]; lane 3 is input A
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            cond_code_e code_l;
            assign code_l = cond_code_e'(cfg[CODE_W*l +: CODE_W]);
            assign conditioned[l] = condition_lane(code_l, lanes[l]);
        end
    endgenerate

    assign term_o = &conditioned;

endmodule

// File: rtl/aoi_unit.sv
module aoi_unit
    import aoi_pkg::*;
(
    input  term_cfg_t [TERMS-1:0] term_cfg,
    input  logic [LANES-1:0]      lanes,
    output logic                  y
);

    logic [TERMS-1:0] term_bits;

    generate
        for (genvar t = 0; t < TERMS; t++) begin : g_term
            aoi_term u_term (
                .cfg    (term_cfg[t]),
                .lanes  (lanes),
                .term_o (term_bits[t])
            );
        end
    endgenerate

    assign y = |term_bits;

endmodule

// File: rtl/aoi_cfg_regs.sv
module aoi_cfg_regs
    import aoi_pkg::*;
#(
    parameter int NREGS  = 6,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [WORD_W-1:0]            cfg_wdata,
    output logic [WORD_W-1:0]            cfg_rdata,
    output logic [NREGS-1:0][WORD_W-1:0] regs_q
);

    logic addr_ok;
    assign addr_ok = ({1'b0, cfg_addr} < (ADDR_W+1)'(NREGS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (cfg_we) begin
            for (int k = 0; k < NREGS; k++) begin
                if (cfg_addr == ADDR_W'(k)) regs_q[k] <= cfg_wdata;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < NREGS; k++) begin
            if (cfg_addr == ADDR_W'(k)) cfg_rdata = regs_q[k];
        end
    end

    generate
        for (genvar k = 0; k < NREGS; k++) begin : g_chk
            // R8
            write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_addr == ADDR_W'(k)) |=> (regs_q[k] == $past(cfg_wdata)));
            // R9
            other_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg_we || cfg_addr != ADDR_W'(k)) |=> $stable(regs_q[k]));
        end
    endgenerate

    // R10
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !addr_ok) |=> $stable(regs_q));

endmodule

// File: rtl/aoi_logic_top.sv
module aoi_logic_top
    import aoi_pkg::*;
#(
    parameter int UNITS = 3,
    localparam int NREGS  = 2 * UNITS,
    localparam int ADDR_W = $clog2(UNITS) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [WORD_W-1:0]       cfg_wdata,
    output logic [WORD_W-1:0]       cfg_rdata,
    input  logic [UNITS*LANES-1:0]  sig_in,
    output logic [UNITS-1:0]        fn_out
);

    logic [NREGS-1:0][WORD_W-1:0] regs_q;

    aoi_cfg_regs #(
        .NREGS  (NREGS),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .regs_q    (regs_q)
    );

    generate
        for (genvar u = 0; u < UNITS; u++) begin : g_unit
            term_cfg_t [TERMS-1:0] unit_cfg;

            for (genvar t = 0; t < TERMS; t++) begin : g_map
                if (t % 2 == 0) begin : g_hi
                    assign unit_cfg[t] = regs_q[2*u + t/2][WORD_W-1 -: TCFG_W];
                end else begin : g_lo
                    assign unit_cfg[t] = regs_q[2*u + t/2][TCFG_W-1:0];
                end
            end

            aoi_unit u_unit (
                .term_cfg (unit_cfg),
                .lanes    (sig_in[LANES*u +: LANES]),
                .y        (fn_out[u])
            );

            // R3
            all_force_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (regs_q[2*u] == '1) |-> fn_out[u]);
            // R4
            all_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (regs_q[2*u] == '0 && regs_q[2*u+1] == '0) |-> !fn_out[u]);
        end
    endgenerate

endmodule

// File: tb/sim_aoi_logic_top.sv
`timescale 1ns/1ps
module sim_aoi_logic_top;

    localparam int UNITS = 3;
    localparam int AW    = $clog2(UNITS) + 1;
    localparam int NCFG  = 8;
    // each entry: {word0, word1} for unit 0
    localparam logic [31:0] CFG_TAB [NCFG] = '{
        32'h0000_0000,   // all off
        32'h5500_0000,   // A&B&C&D
        32'h5F77_D7FD,   // majority | D
        32'h7FDF_F700,   // A|B|C
        32'h6F9F_0000,   // A^B
        32'h0000_00AA,   // ~A&~B&~C&~D in term 3
        32'hFFFF_0000,   // constant one
        32'h00F7_DF00    // C via term1, B via term2
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [UNITS*4-1:0] sig_in = '0;
    logic [UNITS-1:0] fn_out;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    aoi_logic_top #(.UNITS(UNITS)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sig_in(sig_in), .fn_out(fn_out)
    );

    function automatic logic model(input logic [15:0] w0, input logic [15:0] w1,
                                   input logic [3:0] s);
        logic [31:0] both;
        logic acc;
        both = {w0, w1};
        acc = 1'b0;
        for (int t = 0; t < 4; t++) begin
            logic prod;
            logic [7:0] byt;
            byt = both[31 - 8*t -: 8];
            prod = 1'b1;
            for (int k = 0; k < 4; k++) begin
                logic [1:0] c;
                logic x;
                c = byt[7 - 2*k -: 2];
                x = s[3 - k];
                if (c == 2'b00) prod = 1'b0;
                else if (c == 2'b01) prod = prod & x;
                else if (c == 2'b10) prod = prod & ~x;
            end
            acc = acc | prod;
        end
        return acc;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
        cfg_addr = a;
        #1;
        check(req, {16'h0, cfg_rdata}, {16'h0, exp});
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a, b, c, d;
        // R1 reset state
        repeat (3) @(negedge clk);
        sig_in = '1;
        #1;
        check("R1 outputs in reset", {29'h0, fn_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2*UNITS; k++) rd_check("R1 words after reset", AW'(k), 16'h0);
        sig_in = '0;

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NCFG; i++) begin
            wr(AW'(0), CFG_TAB[i][31:16]);
            wr(AW'(1), CFG_TAB[i][15:0]);
            rd_check("R8 readback word0", AW'(0), CFG_TAB[i][31:16]);
            rd_check("R8 readback word1", AW'(1), CFG_TAB[i][15:0]);
            for (int v = 0; v < 16; v++) begin
                sig_in[3:0] = 4'(v);
                #1;
                check("R2 R3 R4 R5 R6 R7 sweep", {31'h0, fn_out[0]},
                      {31'h0, model(CFG_TAB[i][31:16], CFG_TAB[i][15:0], 4'(v))});
            end
        end

        // R12 majority | D against a plain expression
        wr(AW'(0), 16'h5F77);
        wr(AW'(1), 16'hD7FD);
        for (int v = 0; v < 16; v++) begin
            sig_in[3:0] = 4'(v);
            {a, b, c, d} = 4'(v);
            #1;
            check("R12 majority|D", {31'h0, fn_out[0]}, {31'h0, (a&b)|(a&c)|(b&c)|d});
        end
        // R12 A|B|C
        wr(AW'(0), 16'h7FDF);
        wr(AW'(1), 16'hF700);
        for (int v = 0; v < 16; v++) begin
            sig_in[3:0] = 4'(v);
            {a, b, c, d} = 4'(v);
            #1;
            check("R12 A|B|C", {31'h0, fn_out[0]}, {31'h0, a|b|c});
        end
        // R5 inversion gives A^B
        wr(AW'(0), 16'h6F9F);
        wr(AW'(1), 16'h0000);
        for (int v = 0; v < 16; v++) begin
            sig_in[3:0] = 4'(v);
            {a, b, c, d} = 4'(v);
            #1;
            check("R5 A^B", {31'h0, fn_out[0]}, {31'h0, a^b});
        end

        // R11 combinational response mid-cycle
        @(negedge clk);
        sig_in[3:0] = 4'b1000;
        #0.5;
        check("R11 same-cycle rise", {31'h0, fn_out[0]}, 32'h1);
        sig_in[3:0] = 4'b1100;
        #0.5;
        check("R11 same-cycle fall", {31'h0, fn_out[0]}, 32'h0);

        // R9 unit independence
        sig_in = '0;
        wr(AW'(2), 16'hFFFF);
        #1;
        check("R9 unit1 forced high", {29'h0, fn_out}, 32'h2);
        rd_check("R9 unit0 word0 kept", AW'(0), 16'h6F9F);
        rd_check("R9 unit2 word1 untouched", AW'(5), 16'h0);
        wr(AW'(5), 16'h00AA);
        sig_in[11:8] = 4'b0000;
        #1;
        check("R9 unit2 NOR zero in", {31'h0, fn_out[2]}, 32'h1);
        sig_in[11:8] = 4'b0001;
        #1;
        check("R9 unit2 NOR one in", {31'h0, fn_out[2]}, 32'h0);
        check("R9 unit1 still high", {31'h0, fn_out[1]}, 32'h1);

        // R10 unmapped addresses
        wr(AW'(6), 16'hFFFF);
        wr(AW'(7), 16'h1234);
        rd_check("R10 read unmapped 6", AW'(6), 16'h0);
        rd_check("R10 read unmapped 7", AW'(7), 16'h0);
        rd_check("R10 word0 kept", AW'(0), 16'h6F9F);
        rd_check("R10 word2 kept", AW'(2), 16'hFFFF);
        rd_check("R10 word4 kept", AW'(4), 16'h0);
        rd_check("R10 word5 kept", AW'(5), 16'h00AA);

        // R1 reset during operation
        sig_in = '0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 outputs cleared by reset", {29'h0, fn_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_check("R1 word2 cleared", AW'(2), 16'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule